// File: doc/BRIEF.md
# Fractional Baud Generator with Modulation

This block produces the bit timing for a serial port from a clock whose frequency is not an integer multiple of the wanted baud rate. A 16-bit divisor, assembled from a high byte and a low byte, sets the whole number of clocks per bit. An 8-bit modulation pattern then lengthens selected bits of a character by one clock each. Over eight bits, the mean bit period is the divisor plus the number of set pattern bits divided by eight.

A `run` input both enables the generator and restarts it. While `run` is low the counter and the pattern index are held at zero. Once `run` rises, the block emits a one-cycle strobe in the last clock of each bit and a one-cycle sample strobe near the middle of each bit. In synchronous mode the pattern is ignored, the minimum divisor is lower, and a serial clock is produced that is high during the second half of each bit.

Top module: `frac_baud_gen`

## Requirements
- R1: While `run` is low, `bit_tick` and `sample_tick` stay 0 and `sclk` is 0 from the following cycle on. Every new start uses pattern bit 0 for the first bit.
- R2: The divisor D is `{div_hi, div_lo}`, with `div_hi` as bits 15..8 and `div_lo` as bits 7..0.
- R3: In asynchronous mode (`sync_mode`=0), bit i of a run lasts D + `mod_pat[i mod 8]` clocks. Here `mod_pat[0]` is the pattern's least significant bit.
- R4: The pattern index wraps from bit 7 back to bit 0, so the ninth bit of a run uses `mod_pat[0]` again.
- R5: In asynchronous mode, a divisor below 3 is treated as 3.
- R6: In synchronous mode (`sync_mode`=1), every bit lasts exactly D clocks whatever `mod_pat` holds.
- R7: In synchronous mode, a divisor below 2 is treated as 2.
- R8: For a bit of length L, `bit_tick` is high only in the L-th clock of the bit. `sample_tick` is high only in clock floor((L-1)/2)+1 of the bit. The two strobes are never high together.
- R9: In synchronous mode, `sclk` goes to 1 the cycle after `sample_tick` and to 0 the cycle after `bit_tick`. In asynchronous mode `sclk` stays 0.
- R10: The first bit starts in the first cycle in which `run` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_hi | input | 8 | Divisor high byte |
| div_lo | input | 8 | Divisor low byte |
| mod_pat | input | 8 | Modulation pattern, bit i stretches bit i of a character |
| run | input | 1 | Enable; low holds the generator at the start of a character |
| sync_mode | input | 1 | 1 selects synchronous mode |
| bit_tick | output | 1 | Strobe in the last clock of each bit |
| sample_tick | output | 1 | Strobe near the middle of each bit |
| sclk | output | 1 | Serial clock for synchronous mode |

## Verification
A wrong pattern index shows at the ports as a bit that is one clock too long or too short. Because the tests use uneven patterns, the error appears within the first eight bits of a run; an index that fails to restart shows in the very first bit after `run` rises again. A wrong clamp or wrong divisor assembly changes every bit period, so the first `bit_tick` arrives in the wrong cycle. A miscounted midpoint moves `sample_tick` and, in synchronous mode, the `sclk` edge one cycle later, within the same bit.

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int BYTE_W    = 8,
  parameter int MOD_W     = 8,
  parameter int ASYNC_MIN = 3,
  parameter int SYNC_MIN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] div_hi,
  input  logic [BYTE_W-1:0] div_lo,
  input  logic [MOD_W-1:0]  mod_pat,
  input  logic              run,
  input  logic              sync_mode,
  output logic              bit_tick,
  output logic              sample_tick,
  output logic              sclk
);
  localparam int DIV_W = 2 * BYTE_W;
  localparam int LEN_W = DIV_W + 1;
  localparam int IDX_W = (MOD_W > 1) ? $clog2(MOD_W) : 1;

  logic [DIV_W-1:0] div_raw, div_min, div_eff;
  logic [LEN_W-1:0] bit_len, cnt, last_val, mid_val;
  logic [IDX_W-1:0] idx;
  logic             stretch, at_last, at_mid;

  assign div_raw  = {div_hi, div_lo};
  assign div_min  = sync_mode ? DIV_W'(SYNC_MIN) : DIV_W'(ASYNC_MIN);
  assign div_eff  = (div_raw < div_min) ? div_min : div_raw;
  assign stretch  = ~sync_mode & mod_pat[idx];
  assign bit_len  = {1'b0, div_eff} + LEN_W'(stretch);
  assign last_val = bit_len - LEN_W'(1);
  assign mid_val  = last_val >> 1;
  assign at_last  = (cnt >= last_val);
  assign at_mid   = (cnt == mid_val) & ~at_last;

  assign bit_tick    = run & at_last;
  assign sample_tick = run & at_mid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      idx <= '0;
    end else if (!run) begin
      cnt <= '0;
      idx <= '0;
    end else if (at_last) begin
      cnt <= '0;
      idx <= (idx == IDX_W'(MOD_W - 1)) ? '0 : idx + IDX_W'(1);
    end else begin
      cnt <= cnt + LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 sclk <= 1'b0;
    else if (!run || !sync_mode) sclk <= 1'b0;
    else if (sample_tick)       sclk <= 1'b1;
    else if (bit_tick)          sclk <= 1'b0;
  end

  p_strobes_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_tick && sample_tick));

  p_no_back_to_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |=> !bit_tick);

  p_restart_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0) && (idx == '0) && !sclk);

  p_idx_steps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && bit_tick) |=> (idx == (($past(idx) == IDX_W'(MOD_W - 1)) ? '0 : $past(idx) + IDX_W'(1))));

  p_async_sclk_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sync_mode) |-> !sclk);

  p_sclk_moves_on_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk) |-> ($past(bit_tick) || $past(sample_tick) || !$past(run) || !$past(sync_mode)));
endmodule

// File: tb/tb_frac_baud_gen.sv
`timescale 1ns/1ps
module tb_frac_baud_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div_hi = '0, div_lo = '0, mod_pat = '0;
  logic       run = 1'b0, sync_mode = 1'b0;
  logic       bit_tick, sample_tick, sclk;
  int         vectors = 0, miscompares = 0;
  bit         finished = 1'b0;

  always #2.5 clk = ~clk;

  frac_baud_gen dut (
    .clk(clk), .rst_n(rst_n), .div_hi(div_hi), .div_lo(div_lo), .mod_pat(mod_pat),
    .run(run), .sync_mode(sync_mode), .bit_tick(bit_tick), .sample_tick(sample_tick), .sclk(sclk)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int eff_div(input int d, input bit sy);
    int mn = sy ? 2 : 3;
    return (d < mn) ? mn : d;
  endfunction

  task automatic setup(input int d, input logic [7:0] m, input bit sy);
    @(negedge clk);
    run = 1'b0; div_hi = d[15:8]; div_lo = d[7:0]; mod_pat = m; sync_mode = sy;
    @(negedge clk);
    @(negedge clk);
    run = 1'b1;
    #1;
  endtask

  // Called right after run rises: measures nbits bits, sampled mid-low phase
  task automatic measure(input int nbits, input int d, input logic [7:0] m, input bit sy, input string req);
    bit exp_s = 1'b0;
    for (int b = 0; b < nbits; b++) begin
      int len = eff_div(d, sy) + ((sy == 1'b0 && m[b % 8]) ? 1 : 0);
      int c = 0, spos = -1, sbad = 0;
      bit got = 1'b0;
      while (!got && c < 70000) begin
        c++;
        if (sample_tick) begin
          if (spos < 0) spos = c; else sbad++;
        end
        if (sclk != exp_s) sbad++;
        if (sy && sample_tick) exp_s = 1'b1;
        if (sy && bit_tick) exp_s = 1'b0;
        got = bit_tick;
        @(negedge clk);
        #1;
      end
      check({req, " bit length"}, c, len);
      check("R8 sample position", spos, ((len - 1) / 2) + 1);
      check("R9 sclk shape", sbad, 0);
    end
  endtask

  task automatic t_reset_idle;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1;
      check("R1 idle bit_tick", bit_tick, 0);
      check("R1 idle sample_tick", sample_tick, 0);
      check("R1 idle sclk", sclk, 0);
    end
  endtask

  task automatic t_async_pattern;
    setup(5, 8'b1011_0010, 1'b0);
    measure(10, 5, 8'b1011_0010, 1'b0, "R3/R4/R10 async");
  endtask

  task automatic t_async_clamp;
    setup(1, 8'b0000_0101, 1'b0);
    measure(4, 1, 8'b0000_0101, 1'b0, "R5 async clamp");
    setup(0, 8'b1111_1111, 1'b0);
    measure(2, 0, 8'b1111_1111, 1'b0, "R5 async zero divisor");
  endtask

  task automatic t_wide_divisor;
    setup(16'h0102, 8'b0000_0010, 1'b0);
    measure(2, 16'h0102, 8'b0000_0010, 1'b0, "R2 wide divisor");
  endtask

  task automatic t_sync_mode;
    setup(4, 8'b1111_1111, 1'b1);
    measure(3, 4, 8'b1111_1111, 1'b1, "R6 sync ignores pattern");
    setup(7, 8'b0101_0101, 1'b1);
    measure(2, 7, 8'b0101_0101, 1'b1, "R6 sync odd divisor");
    setup(1, 8'b0000_0000, 1'b1);
    measure(3, 1, 8'b0000_0000, 1'b1, "R7 sync clamp");
  endtask

  task automatic t_restart;
    setup(4, 8'b0000_0110, 1'b0);
    measure(2, 4, 8'b0000_0110, 1'b0, "R3 before restart");
    @(negedge clk);
    run = 1'b0;
    for (int i = 0; i < 3; i++) begin
      #1;
      check("R1 stopped bit_tick", bit_tick, 0);
      check("R1 stopped sample_tick", sample_tick, 0);
      @(negedge clk);
    end
    run = 1'b1;
    #1;
    measure(3, 4, 8'b0000_0110, 1'b0, "R1 restart at pattern bit 0");
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #1;
    check("R1 reset bit_tick", bit_tick, 0);
    check("R1 reset sclk", sclk, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_idle();
    t_async_pattern();
    t_async_clamp();
    t_wide_divisor();
    t_sync_mode();
    t_restart();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule